// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Flow Control

This block turns bytes written by a processor into an asynchronous serial bit stream. A byte written on the buffer port waits in a one-entry holding register. When the shift register is free, the byte moves into it and a one-cycle transmit-request pulse tells software that another byte may be written. The line output carries frames made of a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts sixteen pulses of an oversampling clock-enable input. Bit periods follow a free-running phase counter, so every frame begins on a bit-clock boundary.

An optional handshake lets a far-end receiver pause the stream with an active-low clear-to-send input. The input is resynchronised through two flops. It is consulted only when a frame is about to begin, so a frame that has started always runs to its stop bit. While the line is held off, the request pulse still fires when the buffer drains into the shifter. Software can then load one further byte, which waits until the line is released.

Top module: `serial_tx_cts`

## Requirements
- R1: Out of reset `txd` is high, `busy` is low, `tx_irq` is low and `wr_ovr` is low. `txd` stays high whenever no frame is being sent.
- R2: A frame is one low start bit, then data bits 0 through 7 in that order, then one high stop bit. Each bit is held for exactly 16 `tick` pulses.
- R3: A write with `wr_en` high is accepted only while the holding register is empty. The byte moves to the shift register when the shifter is empty. `tx_irq` is high for exactly one cycle on each such move, so every accepted byte yields exactly one pulse.
- R4: If a byte is waiting in the holding register when a frame's stop bit ends, and sending is allowed, the next start bit follows at once with no idle bit time.
- R5: With `hs_en` low, `cts_n` has no effect and queued frames are sent.
- R6: With `hs_en` high, no frame starts while the synchronised `cts_n` is high. A frame already started completes all ten bits even if `cts_n` rises during it.
- R7: While sending is held off, the move from holding register to shifter still takes place and raises `tx_irq`. One more byte may then be written, and it is sent after the held one.
- R8: A start bit only begins on a bit-clock boundary, the tick that completes each group of 16 ticks counted from reset. After `cts_n` falls, the held frame starts within 18 ticks.
- R9: A write while the holding register is full is discarded and sets the sticky `wr_ovr` flag. A high `ovr_clr` clears the flag and takes priority over setting it.
- R10: `busy` is high from the start of the start bit until the end of the stop bit. Between back-to-back frames it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling clock-enable, 16 per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| hs_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Active-low clear-to-send from the far end |
| ovr_clr | input | 1 | Clears the write-overrun flag |
| txd | output | 1 | Serial data line, idles high |
| tx_irq | output | 1 | One-cycle pulse when a byte enters the shifter |
| busy | output | 1 | High while a frame is on the line |
| wr_ovr | output | 1 | Sticky flag for a discarded write |

## Verification
The hardest state to reach is the double hold. It needs one byte parked in the shifter and a second in the holding register while clear-to-send is deasserted, followed by a release that must send both in order. A third write during this state must be discarded. The stimulus enables the handshake with `cts_n` high and loads two bytes, waiting for the request pulse between them. It then writes a third byte and checks that the overrun flag rises. Finally it drops `cts_n` and measures in ticks how long the first start bit takes. A second directed case raises `cts_n` in the middle of a frame that has a successor queued. Randomised rounds then vary the handshake setting, `cts_n` toggle times and the tick spacing.

// File: rtl/serial_tx_cts.sv
module serial_tx_cts #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          hs_en,
  input  logic          cts_n,
  input  logic          ovr_clr,
  output logic          txd,
  output logic          tx_irq,
  output logic          busy,
  output logic          wr_ovr
);
  localparam int CW = $clog2(OSR);
  localparam int FW = DW + 2;
  localparam int BW = $clog2(FW + 1);

  logic [CW-1:0] ph;
  logic [1:0]    cts_q;
  logic          buf_full;
  logic [DW-1:0] buf_q;
  logic          held, sending;
  logic [FW-1:0] fr;
  logic [BW-1:0] nbit;
  logic          bnd, go_ok, last, take, start;

  assign bnd   = tick && (ph == CW'(OSR - 1));
  assign go_ok = !hs_en || !cts_q[1];
  assign last  = sending && bnd && (nbit == BW'(FW - 1));
  assign take  = buf_full && ((!held && !sending) || last);
  assign start = go_ok && ((held && bnd) || (last && buf_full));

  assign txd  = sending ? fr[0] : 1'b1;
  assign busy = sending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      cts_q <= 2'b11;
    end else begin
      cts_q <= {cts_q[0], cts_n};
      if (tick) ph <= (ph == CW'(OSR - 1)) ? '0 : ph + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
      wr_ovr   <= 1'b0;
      tx_irq   <= 1'b0;
    end else begin
      tx_irq <= take;
      if (take) buf_full <= 1'b0;
      if (wr_en && !buf_full) begin
        buf_full <= 1'b1;
        buf_q    <= wr_data;
      end
      if (ovr_clr) wr_ovr <= 1'b0;
      else if (wr_en && buf_full) wr_ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= 1'b0;
      sending <= 1'b0;
      fr      <= '1;
      nbit    <= '0;
    end else begin
      if (take) fr <= {1'b1, buf_q, 1'b0};
      else if (sending && bnd) fr <= {1'b1, fr[FW-1:1]};

      if (start) nbit <= '0;
      else if (sending && bnd) nbit <= nbit + 1'b1;

      if (start) sending <= 1'b1;
      else if (last) sending <= 1'b0;

      if (start) held <= 1'b0;
      else if (take) held <= 1'b1;
    end
  end
endmodule

module serial_tx_cts_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic txd,
  input logic tx_irq,
  input logic hs_en,
  input logic cts_s,
  input logic bnd,
  input logic wr_en,
  input logic buf_full,
  input logic ovr_clr,
  input logic wr_ovr
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  a_r3_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
  a_r6_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !($past(hs_en) && $past(cts_s)));
  a_r8_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != $past(busy)) |-> $past(bnd));
  a_r9_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && buf_full && !ovr_clr) |=> wr_ovr);
  a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr |=> !wr_ovr);
endmodule

bind serial_tx_cts serial_tx_cts_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .txd(txd), .tx_irq(tx_irq),
  .hs_en(hs_en), .cts_s(cts_q[1]), .bnd(bnd), .wr_en(wr_en),
  .buf_full(buf_full), .ovr_clr(ovr_clr), .wr_ovr(wr_ovr)
);

// File: tb/sim_serial_tx_cts.sv
module sim_serial_tx_cts;
  localparam int CLK_NS = 10;
  localparam int OSR    = 16;
  localparam int FRAME  = OSR * 10;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, hs_en = 0, cts_n = 1, ovr_clr = 0;
  logic [7:0] wr_data = 0;
  logic txd, tx_irq, busy, wr_ovr;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, n_acc = 0, n_b2b = 0, n_frames = 0;
  int unsigned tcnt = 0, base = 0, rel_t = 0;
  int ph = 0, last_ph = -1;
  bit mon_act = 0, rel_arm = 0, busy_ok = 1, idle_bad = 0, done = 0;
  logic [7:0] rx = 0;
  logic [7:0] expq[$];

  serial_tx_cts u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .hs_en(hs_en), .cts_n(cts_n), .ovr_clr(ovr_clr), .txd(txd),
    .tx_irq(tx_irq), .busy(busy), .wr_ovr(wr_ovr)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return b[k-1];
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial forever begin
    @(negedge clk);
    tick = ($urandom % 3) == 0;
  end

  always @(posedge clk) if (rst_n && tick) tcnt <= tcnt + 1;

  task automatic open_frame();
    mon_act = 1; base = tcnt; last_ph = -1; busy_ok = 1; n_frames++;
    check(tcnt % OSR == 0, "R8 start on boundary", int'(tcnt % OSR), 0);
    if (rel_arm) begin
      check(tcnt - rel_t <= 18, "R8 start after release", int'(tcnt - rel_t), 18);
      rel_arm = 0;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (tx_irq) irq_cnt++;
    if (!mon_act) begin
      if (busy) open_frame();
      else if (!txd) idle_bad = 1;
    end else begin
      ph = int'(tcnt - base);
      if (ph >= FRAME) begin
        check(busy_ok, "R10 busy through frame", 0, 1);
        if (expq.size() == 0) check(0, "R2 unexpected frame", rx, -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(rx == e, "R2 frame data", rx, e);
        end
        if (busy) begin n_b2b++; open_frame(); end
        else mon_act = 0;
      end else begin
        if (!busy) busy_ok = 0;
        if (ph % OSR == OSR/2 && ph != last_ph) begin
          int k;
          last_ph = ph;
          k = ph / OSR;
          if (k == 0 || k == 9) check(txd == exp_bit(8'h00, k), "R2 start/stop bit", txd, exp_bit(8'h00, k));
          else rx[k-1] = txd;
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit expect_ok);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
    if (expect_ok) begin expq.push_back(b); n_acc++; end
  endtask

  task automatic wait_irq(input int target, input string req);
    int g = 0;
    while (irq_cnt < target && g < 5000) begin @(negedge clk); g++; end
    check(irq_cnt >= target, req, irq_cnt, target);
  endtask

  task automatic wait_idle();
    int g = 0;
    do begin @(negedge clk); g++; end
    while ((busy || mon_act || expq.size() != 0) && g < 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int t, fb;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check(txd == 1, "R1 reset txd", txd, 1);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(tx_irq == 0, "R1 reset irq", tx_irq, 0);
    check(wr_ovr == 0, "R1 reset ovr", wr_ovr, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    t = irq_cnt + 1;
    send(8'hA5, 1);
    wait_irq(t, "R3 irq after write");
    wait_idle();

    fb = n_b2b;
    t = irq_cnt + 1; send(8'h3C, 1); wait_irq(t, "R3 irq first");
    t = irq_cnt + 1; send(8'hC3, 1); wait_irq(t, "R3 irq second");
    wait_idle();
    check(n_b2b == fb + 1, "R4 back to back", n_b2b - fb, 1);

    hs_en = 0; cts_n = 1;
    fb = n_frames;
    send(8'h81, 1);
    wait_idle();
    check(n_frames == fb + 1, "R5 cts ignored", n_frames - fb, 1);

    hs_en = 1; cts_n = 1;
    repeat (4) @(negedge clk);
    t = irq_cnt + 1;
    send(8'h5A, 1);
    repeat (3) @(negedge clk);
    check(irq_cnt == t, "R7 irq while halted", irq_cnt, t);
    send(8'h96, 1);
    repeat (600) @(negedge clk);
    check(busy == 0, "R6 no start while cts high", busy, 0);
    check(wr_ovr == 0, "R9 held write not overrun", wr_ovr, 0);
    send(8'hFF, 0);
    @(negedge clk);
    check(wr_ovr == 1, "R9 overrun flag set", wr_ovr, 1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0; @(negedge clk);
    check(wr_ovr == 0, "R9 overrun flag cleared", wr_ovr, 0);
    cts_n = 0; rel_t = tcnt; rel_arm = 1;
    wait_idle();
    check(irq_cnt == n_acc, "R7 irq count after hold", irq_cnt, n_acc);

    hs_en = 1; cts_n = 0;
    t = irq_cnt + 1; send(8'h11, 1); wait_irq(t, "R3 irq");
    t = irq_cnt + 1; send(8'h22, 1);
    while (!busy) @(negedge clk);
    repeat (40) @(negedge clk);
    cts_n = 1;
    while (busy) @(negedge clk);
    repeat (600) @(negedge clk);
    check(busy == 0, "R6 halted after frame", busy, 0);
    check(expq.size() == 1, "R6 frame completed", expq.size(), 1);
    check(irq_cnt == t, "R7 irq for held byte", irq_cnt, t);
    cts_n = 0; rel_t = tcnt; rel_arm = 1;
    wait_idle();

    for (int i = 0; i < 30; i++) begin
      hs_en = $urandom % 2;
      cts_n = $urandom % 2;
      t = irq_cnt + 1;
      send(8'($urandom), 1);
      repeat ($urandom % 400) @(negedge clk);
      cts_n = $urandom % 2;
      repeat ($urandom % 200) @(negedge clk);
      cts_n = 0;
      wait_irq(t, "R3 random irq");
    end
    cts_n = 0;
    wait_idle();
    check(irq_cnt == n_acc, "R3 one irq per byte", irq_cnt, n_acc);
    check(expq.size() == 0, "R2 all bytes sent", expq.size(), 0);
    check(!idle_bad, "R1 idle line high", idle_bad, 0);
    summary();
  end
endmodule